// File: doc/BRIEF.md
# Dual-Channel ADC Window Wakeup Controller

This block sits in the always-on domain and runs a two-channel analog-to-digital converter while the rest of the chip sleeps. It powers the converter up, converts channel 0 and then channel 1, and compares each 10-bit sample against a programmed inclusive window for that channel. A round counts as a hit only when both samples fall inside their windows.

Detection is debounced in two stages. In the first stage the controller duty-cycles the converter: after each round it holds the converter in powerdown for a programmed number of idle cycles. Once a programmed number of consecutive rounds have hit, the controller keeps the converter powered and runs rounds back to back. A second programmed run of consecutive hits in this stage raises a wakeup request. The controller also freezes the two samples of the round that fired, so that software can read them after it wakes. A miss in either stage clears the count and returns the controller to duty-cycled scanning.

Top module: `adc_wake_ctrl`

## Requirements
- R1: A sample matches its channel when the channel's window-enable input is 1 and lo <= sample <= hi, with both bounds inclusive. A round hits only when both channels match. With the window-enable at 0, no round ever hits.
- R2: Each round converts channel 0 first and then channel 1. `adc_chsel_o` is 0 while the controller waits for the channel 0 sample and 1 while it waits for the channel 1 sample. The first `adc_valid_i` pulse in each phase supplies that channel's sample.
- R3: After enabling, the converter leaves powerdown and stays powered for at least 2 cycles of settling before a sample is accepted. Between duty-cycled rounds, `adc_pd_o` stays high for exactly `sleep_cycles_i` cycles, where a value of 0 acts as 1.
- R4: After `lp_rounds_i` consecutive hits in duty-cycled mode, the controller enters continuous mode. In continuous mode `adc_pd_o` stays low between rounds.
- R5: After a further `np_rounds_i` consecutive hits in continuous mode, `wakeup_o` rises in the cycle after the evaluation of the firing round, and never earlier.
- R6: Any miss clears the hit count. A miss in continuous mode also returns the controller to duty-cycled mode, which sleeps before the next round.
- R7: When `wakeup_o` rises, `trig_ch0_o` and `trig_ch1_o` hold the channel 0 and channel 1 samples of the firing round. They stay stable while the request is held.
- R8: `wakeup_o` stays high, with the converter in powerdown, until `enable_i` goes low. A low `enable_i` returns the controller to its powered-down idle state and clears `wakeup_o`.
- R9: During reset `adc_pd_o` is 1, `adc_chsel_o` is 0, `wakeup_o` is 0 and both triggered values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on clock |
| rst_aon_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Run the controller; low forces idle and clears wakeup |
| ch0_lo_i | input | 10 | Channel 0 window lower bound (inclusive) |
| ch0_hi_i | input | 10 | Channel 0 window upper bound (inclusive) |
| ch0_inwin_i | input | 1 | Channel 0 window-match enable |
| ch1_lo_i | input | 10 | Channel 1 window lower bound (inclusive) |
| ch1_hi_i | input | 10 | Channel 1 window upper bound (inclusive) |
| ch1_inwin_i | input | 1 | Channel 1 window-match enable |
| lp_rounds_i | input | 8 | Consecutive hits needed in duty-cycled mode (typically 8) |
| np_rounds_i | input | 8 | Consecutive hits needed in continuous mode (typically 8) |
| sleep_cycles_i | input | 16 | Powerdown cycles between duty-cycled rounds |
| adc_pd_o | output | 1 | Converter powerdown |
| adc_chsel_o | output | 1 | Channel being converted (0 or 1) |
| adc_valid_i | input | 1 | Converter sample-valid pulse |
| adc_sample_i | input | 10 | Converter sample |
| wakeup_o | output | 1 | Wakeup request |
| trig_ch0_o | output | 10 | Channel 0 sample of the firing round |
| trig_ch1_o | output | 10 | Channel 1 sample of the firing round |

## Verification
The bench sweeps a single bad round over seven positions. The bad round misses on channel 0 only, on channel 1 only, or on both. Positions early in the sweep fall in the duty-cycled stage and later ones in the continuous stage, so the bench can tell a count restart from a mode fallback by the round on which the wakeup fires and by the number of powerdown pulses. Sample values cycle through the exact window bounds, interior points and the codes just outside each bound, which separates inclusive comparison from exclusive comparison. Further runs cover a long glitch-then-hit sequence with thresholds of 8, thresholds of 1 with a one-cycle sleep, and a disabled window that must never wake. Each fire also checks the latched sample pair and how long the request is held.

// File: rtl/adc_wake_pkg.sv
package adc_wake_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PWRUP = 3'd1,
    S_CONV0 = 3'd2,
    S_CONV1 = 3'd3,
    S_EVAL  = 3'd4,
    S_SLEEP = 3'd5,
    S_WAKE  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/adc_window_match.sv
module adc_window_match #(
  parameter int SW = 10
) (
  input  logic [SW-1:0] sample_i,
  input  logic [SW-1:0] lo_i,
  input  logic [SW-1:0] hi_i,
  input  logic          inwin_i,
  output logic          match_o
);

  logic above_lo;
  logic below_hi;

  always_comb begin
    above_lo = (sample_i >= lo_i);
    below_hi = (sample_i <= hi_i);
    match_o  = inwin_i & above_lo & below_hi;
  end

endmodule

// File: rtl/adc_round_seq.sv
module adc_round_seq
  import adc_wake_pkg::*;
#(
  parameter int SW        = 10,
  parameter int TMR_W     = 16,
  parameter int PWRUP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [TMR_W-1:0] sleep_cycles_i,
  input  logic             adc_valid_i,
  input  logic [SW-1:0]    adc_sample_i,
  input  logic             next_np_i,
  input  logic             fire_i,
  output logic             adc_pd_o,
  output logic             adc_chsel_o,
  output logic             round_done_o,
  output logic [SW-1:0]    samp0_o,
  output logic [SW-1:0]    samp1_o
);

  localparam logic [TMR_W:0] PWRUP_LIM = (TMR_W+1)'(PWRUP_CYC);

  seq_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TMR_W:0]   tmr_inc;
  logic [SW-1:0]    s0_q, s1_q;
  logic             s0_en, s1_en;
  logic             pwrup_done, sleep_done;

  assign tmr_inc    = {1'b0, tmr_q} + 1'b1;
  assign pwrup_done = (tmr_inc >= PWRUP_LIM);
  assign sleep_done = (tmr_inc >= {1'b0, sleep_cycles_i});

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    s0_en   = 1'b0;
    s1_en   = 1'b0;
    if (!enable_i) begin
      state_d = S_IDLE;
      tmr_d   = '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          state_d = S_PWRUP;
          tmr_d   = '0;
        end
        S_PWRUP: begin
          if (pwrup_done) begin
            state_d = S_CONV0;
            tmr_d   = '0;
          end else begin
            tmr_d = tmr_inc[TMR_W-1:0];
          end
        end
        S_CONV0: begin
          if (adc_valid_i) begin
            s0_en   = 1'b1;
            state_d = S_CONV1;
          end
        end
        S_CONV1: begin
          if (adc_valid_i) begin
            s1_en   = 1'b1;
            state_d = S_EVAL;
          end
        end
        S_EVAL: begin
          tmr_d = '0;
          if (fire_i)         state_d = S_WAKE;
          else if (next_np_i) state_d = S_CONV0;
          else                state_d = S_SLEEP;
        end
        S_SLEEP: begin
          if (sleep_done) begin
            state_d = S_PWRUP;
            tmr_d   = '0;
          end else begin
            tmr_d = tmr_inc[TMR_W-1:0];
          end
        end
        S_WAKE:  state_d = S_WAKE;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
    end else if (s0_en) begin
      s0_q <= adc_sample_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
    end else if (s1_en) begin
      s1_q <= adc_sample_i;
    end
  end

  assign adc_pd_o     = (state_q == S_IDLE) || (state_q == S_SLEEP) || (state_q == S_WAKE);
  assign adc_chsel_o  = (state_q == S_CONV1);
  assign round_done_o = (state_q == S_EVAL);
  assign samp0_o      = s0_q;
  assign samp1_o      = s1_q;

  // R3: a conversion phase is only entered after the settling window
  generate
    if (PWRUP_CYC >= 2) begin : g_pwrup_chk
      p_pwrup_settle_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == S_CONV0 && $past(state_q) == S_PWRUP) |-> $past(state_q, 2) == S_PWRUP);
    end
  endgenerate

  // R2: channel 1 is selected only directly after a channel 0 sample was taken
  p_sel_order_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_chsel_o) |-> $past(adc_valid_i) && !$past(adc_chsel_o));

  // R3: powerdown is lifted only when the controller is enabled
  p_pd_fall_enabled_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_pd_o) |-> $past(enable_i));

endmodule

// File: rtl/adc_wake_debounce.sv
module adc_wake_debounce #(
  parameter int SW    = 10,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] lp_thr_i,
  input  logic [CNT_W-1:0] np_thr_i,
  input  logic             round_done_i,
  input  logic             round_hit_i,
  input  logic [SW-1:0]    samp0_i,
  input  logic [SW-1:0]    samp1_i,
  output logic             next_np_o,
  output logic             fire_o,
  output logic             np_mode_o,
  output logic             wakeup_o,
  output logic [SW-1:0]    trig0_o,
  output logic [SW-1:0]    trig1_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             np_q, np_d;
  logic             wake_q, wake_d;
  logic             upd_en;
  logic             hit_evt;
  logic             lp_reach, np_reach;
  logic             to_np, fire, next_np;
  logic [SW-1:0]    trig0_q, trig1_q;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    hit_evt  = round_done_i & round_hit_i;
    lp_reach = (cnt_inc >= {1'b0, lp_thr_i});
    np_reach = (cnt_inc >= {1'b0, np_thr_i});
    to_np    = hit_evt & ~np_q & lp_reach;
    fire     = hit_evt & np_q & np_reach;
    next_np  = to_np | (hit_evt & np_q & ~np_reach);
  end

  always_comb begin
    upd_en = ~enable_i | round_done_i;
    cnt_d  = cnt_q;
    np_d   = np_q;
    wake_d = wake_q;
    if (!enable_i) begin
      cnt_d  = '0;
      np_d   = 1'b0;
      wake_d = 1'b0;
    end else if (round_done_i) begin
      if (round_hit_i) begin
        cnt_d  = (to_np | fire) ? '0 : cnt_inc[CNT_W-1:0];
        np_d   = next_np;
        wake_d = wake_q | fire;
      end else begin
        cnt_d = '0;
        np_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      np_q   <= 1'b0;
      wake_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      np_q   <= np_d;
      wake_q <= wake_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig0_q <= '0;
      trig1_q <= '0;
    end else if (fire) begin
      trig0_q <= samp0_i;
      trig1_q <= samp1_i;
    end
  end

  assign next_np_o = next_np;
  assign fire_o    = fire;
  assign np_mode_o = np_q;
  assign wakeup_o  = wake_q;
  assign trig0_o   = trig0_q;
  assign trig1_o   = trig1_q;

  // R8: the request is held while enabled
  p_wake_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_q && enable_i) |=> wake_q);

  // R8: disabling clears the request
  p_wake_clear_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !wake_q);

  // R7: latched samples do not move while the request is held
  p_trig_stable_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_q && enable_i) |=> ($stable(trig0_q) && $stable(trig1_q)));

  // R6: the hit count never reaches the threshold of its own stage
  p_cnt_bound_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !np_q && lp_thr_i != '0 && $stable(lp_thr_i)) |-> (cnt_q < lp_thr_i));

endmodule

// File: rtl/adc_wake_ctrl.sv
module adc_wake_ctrl #(
  parameter int SW        = 10,
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 16,
  parameter int PWRUP_CYC = 2
) (
  input  logic             clk_aon_i,
  input  logic             rst_aon_ni,
  input  logic             enable_i,
  input  logic [SW-1:0]    ch0_lo_i,
  input  logic [SW-1:0]    ch0_hi_i,
  input  logic             ch0_inwin_i,
  input  logic [SW-1:0]    ch1_lo_i,
  input  logic [SW-1:0]    ch1_hi_i,
  input  logic             ch1_inwin_i,
  input  logic [CNT_W-1:0] lp_rounds_i,
  input  logic [CNT_W-1:0] np_rounds_i,
  input  logic [TMR_W-1:0] sleep_cycles_i,
  output logic             adc_pd_o,
  output logic             adc_chsel_o,
  input  logic             adc_valid_i,
  input  logic [SW-1:0]    adc_sample_i,
  output logic             wakeup_o,
  output logic [SW-1:0]    trig_ch0_o,
  output logic [SW-1:0]    trig_ch1_o
);

  localparam int NUM_CH = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          round_done;
  logic          round_hit;
  logic          next_np;
  logic          fire;
  logic          np_mode;
  logic [SW-1:0] samp0, samp1;

  logic [SW-1:0]     samp_a  [NUM_CH];
  logic [SW-1:0]     lo_a    [NUM_CH];
  logic [SW-1:0]     hi_a    [NUM_CH];
  logic [NUM_CH-1:0] inwin_a;
  logic [NUM_CH-1:0] match_a;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_aon_i or negedge rst_aon_ni) begin
    if (!rst_aon_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  assign samp_a[0] = samp0;
  assign samp_a[1] = samp1;
  assign lo_a[0]   = ch0_lo_i;
  assign lo_a[1]   = ch1_lo_i;
  assign hi_a[0]   = ch0_hi_i;
  assign hi_a[1]   = ch1_hi_i;
  assign inwin_a   = {ch1_inwin_i, ch0_inwin_i};

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      adc_window_match #(.SW(SW)) u_match (
        .sample_i (samp_a[c]),
        .lo_i     (lo_a[c]),
        .hi_i     (hi_a[c]),
        .inwin_i  (inwin_a[c]),
        .match_o  (match_a[c])
      );
    end
  endgenerate

  assign round_hit = &match_a;

  adc_round_seq #(
    .SW        (SW),
    .TMR_W     (TMR_W),
    .PWRUP_CYC (PWRUP_CYC)
  ) u_seq (
    .clk_i          (clk_aon_i),
    .rst_ni         (rst_n),
    .enable_i       (enable_i),
    .sleep_cycles_i (sleep_cycles_i),
    .adc_valid_i    (adc_valid_i),
    .adc_sample_i   (adc_sample_i),
    .next_np_i      (next_np),
    .fire_i         (fire),
    .adc_pd_o       (adc_pd_o),
    .adc_chsel_o    (adc_chsel_o),
    .round_done_o   (round_done),
    .samp0_o        (samp0),
    .samp1_o        (samp1)
  );

  adc_wake_debounce #(
    .SW    (SW),
    .CNT_W (CNT_W)
  ) u_deb (
    .clk_i        (clk_aon_i),
    .rst_ni       (rst_n),
    .enable_i     (enable_i),
    .lp_thr_i     (lp_rounds_i),
    .np_thr_i     (np_rounds_i),
    .round_done_i (round_done),
    .round_hit_i  (round_hit),
    .samp0_i      (samp0),
    .samp1_i      (samp1),
    .next_np_o    (next_np),
    .fire_o       (fire),
    .np_mode_o    (np_mode),
    .wakeup_o     (wakeup_o),
    .trig0_o      (trig_ch0_o),
    .trig1_o      (trig_ch1_o)
  );

  // R5: a request only appears right after a hitting round was evaluated
  p_wake_after_hit_r5 : assert property (@(posedge clk_aon_i) disable iff (!rst_n)
    $rose(wakeup_o) |-> ($past(round_done) && $past(round_hit)));

  // R4: in continuous mode the converter stays powered
  p_np_no_pd_r4 : assert property (@(posedge clk_aon_i) disable iff (!rst_n)
    (np_mode && enable_i) |-> !adc_pd_o);

  // R8: a held request keeps the converter in powerdown
  p_wake_pd_r8 : assert property (@(posedge clk_aon_i) disable iff (!rst_n)
    wakeup_o |-> adc_pd_o);

endmodule

// File: tb/sim_adc_wake_ctrl.sv
module sim_adc_wake_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [9:0] c0lo, c0hi, c1lo, c1hi;
  logic       c0in, c1in;
  logic [7:0] lp_n, np_n;
  logic [15:0] slp;
  logic       pd, sel, valid, wakeup;
  logic [9:0] sample, trig0, trig1;

  always #10 clk = ~clk;

  adc_wake_ctrl u0 (
    .clk_aon_i      (clk),
    .rst_aon_ni     (rst_n),
    .enable_i       (enable),
    .ch0_lo_i       (c0lo),
    .ch0_hi_i       (c0hi),
    .ch0_inwin_i    (c0in),
    .ch1_lo_i       (c1lo),
    .ch1_hi_i       (c1hi),
    .ch1_inwin_i    (c1in),
    .lp_rounds_i    (lp_n),
    .np_rounds_i    (np_n),
    .sleep_cycles_i (slp),
    .adc_pd_o       (pd),
    .adc_chsel_o    (sel),
    .adc_valid_i    (valid),
    .adc_sample_i   (sample),
    .wakeup_o       (wakeup),
    .trig_ch0_o     (trig0),
    .trig_ch1_o     (trig1)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] pat [64];
  int rounds_done = 0;
  int rises = 0;
  int hi_len = 0;
  int last_sleep = 0;
  bit seen_rise = 0;
  bit sleep_seen = 0;
  bit pd_prev = 1'b1;
  int mcnt = 0;

  function automatic logic [1:0] patv(int k);
    return (k < 64) ? pat[k] : 2'b11;
  endfunction

  // sample value for channel ch in round k: bounds, interior, or just outside
  function automatic logic [9:0] sval(int ch, int k);
    int lo, hi, v;
    lo = (ch == 0) ? 128 : 512;
    hi = lo + 127;
    if (patv(k)[ch]) begin
      case (k % 4)
        0: v = lo;
        1: v = hi;
        default: v = lo + ((k * 37) % 128);
      endcase
    end else begin
      v = (k % 2 == 1) ? hi + 1 : lo - 1;
    end
    return v[9:0];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: three cycles per conversion while powered
  initial begin
    valid  = 1'b0;
    sample = '0;
    forever begin
      @(negedge clk);
      if (pd === 1'b1) begin
        mcnt  = 0;
        valid = 1'b0;
        if (!pd_prev) begin
          rises++;
          seen_rise = 1;
          hi_len = 1;
        end else begin
          hi_len++;
        end
      end else begin
        if (pd_prev && seen_rise) begin
          last_sleep = hi_len;
          sleep_seen = 1;
        end
        hi_len = 0;
        if (mcnt == 2) begin
          valid  = 1'b1;
          sample = sval(sel ? 1 : 0, rounds_done);
          if (sel) rounds_done++;
          mcnt = 0;
        end else begin
          valid = 1'b0;
          mcnt++;
        end
      end
      pd_prev = pd;
    end
  end

  // reference debounce from the requirements
  task automatic ref_run(int nlp, int nnp, bit i0, bit i1, int limit,
                         output int fire, output int er);
    int np, cnt;
    bit hit;
    np = 0; cnt = 0; er = 0; fire = -1;
    for (int k = 0; k < limit; k++) begin
      hit = i0 && i1 && (patv(k) == 2'b11);
      if (np == 0) begin
        if (hit) begin
          cnt++;
          if (cnt >= nlp) begin np = 1; cnt = 0; end
          else er++;
        end else begin
          cnt = 0; er++;
        end
      end else begin
        if (hit) begin
          cnt++;
          if (cnt >= nnp) begin fire = k; er++; break; end
        end else begin
          np = 0; cnt = 0; er++;
        end
      end
    end
  endtask

  task automatic run_case(int nlp, int nnp, int wt, bit i0, bit i1, int limit);
    int fire, er, cyc;
    logic [9:0] t0, t1;
    ref_run(nlp, nnp, i0, i1, limit, fire, er);
    @(negedge clk); #2;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R8 disable clears wakeup", wakeup, 0);
    chk("R8 idle powerdown", pd, 1);
    lp_n = nlp[7:0]; np_n = nnp[7:0]; slp = wt[15:0];
    c0in = i0; c1in = i1;
    rounds_done = 0; rises = 0; seen_rise = 0; sleep_seen = 0;
    @(negedge clk); #2;
    enable = 1'b1;
    cyc = 0;
    while (!(wakeup === 1'b1) && rounds_done < limit && cyc < 20000) begin
      @(negedge clk); #2;
      cyc++;
    end
    if (fire >= 0) begin
      chk("R5 wakeup raised", wakeup, 1);
      chk("R5 R6 firing round index", rounds_done, fire + 1);
      chk("R7 R1 R2 trig ch0", trig0, sval(0, fire));
      chk("R7 R1 R2 trig ch1", trig1, sval(1, fire));
      chk("R4 R6 powerdown pulses", rises, er);
      t0 = trig0; t1 = trig1;
      repeat (6) @(negedge clk);
      #2;
      chk("R8 wakeup held", wakeup, 1);
      chk("R8 powerdown while woken", pd, 1);
      chk("R7 trig stable", {t1, t0}, {trig1, trig0});
    end else begin
      repeat (3) @(negedge clk);
      #2;
      chk("R1 R6 no wakeup", wakeup, 0);
      chk("R6 powerdown pulses", rises, er);
    end
    if (sleep_seen) chk("R3 sleep length", last_sleep, (wt < 1) ? 1 : wt);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0;
    c0lo = 10'd128; c0hi = 10'd255; c1lo = 10'd512; c1hi = 10'd639;
    c0in = 1'b1; c1in = 1'b1; lp_n = 8'd3; np_n = 8'd2; slp = 16'd4;
    for (int k = 0; k < 64; k++) pat[k] = 2'b11;
    repeat (3) @(negedge clk);
    #2;
    chk("R9 reset pd", pd, 1);
    chk("R9 reset sel", sel, 0);
    chk("R9 reset wakeup", wakeup, 0);
    chk("R9 reset trig0", trig0, 0);
    chk("R9 reset trig1", trig1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // all hits, short thresholds
    run_case(3, 2, 5, 1'b1, 1'b1, 64);
    // thresholds of one, one-cycle sleep
    run_case(1, 1, 1, 1'b1, 1'b1, 64);

    // single bad round: channel 0, channel 1, or both; swept over positions
    for (int typ = 1; typ <= 3; typ++) begin
      for (int pos = 0; pos < 7; pos++) begin
        for (int k = 0; k < 64; k++) pat[k] = 2'b11;
        pat[pos] = 2'(~typ) & 2'b11;
        run_case(3, 2, 4 + pos, 1'b1, 1'b1, 64);
      end
    end

    // long glitch sequence with thresholds of eight
    for (int k = 0; k < 64; k++) pat[k] = 2'b11;
    pat[5] = 2'b10; pat[8] = 2'b00; pat[14] = 2'b01; pat[17] = 2'b00;
    pat[18] = 2'b00; pat[19] = 2'b00; pat[20] = 2'b00;
    pat[30] = 2'b10;
    run_case(8, 8, 16, 1'b1, 1'b1, 64);

    // window-match disabled on channel 0: never wakes
    for (int k = 0; k < 64; k++) pat[k] = 2'b11;
    run_case(2, 2, 4, 1'b0, 1'b1, 10);

    // disabling after a wake returns to idle
    enable = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk("R8 final disable clears", wakeup, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule